// File: doc/BRIEF.md
# Relocatable Boot ROM Overlay Decoder

This block is the memory-select logic of a small 8-bit processor card with a 16-bit address bus. On every memory request it decides which of three targets answers: the boot ROM, the 1 KiB on-card RAM, or the external system bus. It also produces the local offset that the chosen on-card memory needs. Each of the ROM and the RAM has a 6-bit base value, normally taken from board switches. A base value selects one 1 KiB page of the address map.

Strap inputs set three things: the ROM size (1 KiB or 2 KiB), whether the boot overlay is enabled, and whether the ROM's own window is visible. The overlay works as follows. A boot flag is set by reset. While the flag is set and the overlay strap is on, every read is answered by the ROM, so the processor fetches its first instructions from the ROM at whatever address it starts from. The first real request that touches the ROM window clears the flag, and that request is still served by the ROM. If the window-disable strap is set, the ROM then disappears from the map completely ("phantom" operation). Debug peeks can read through the decoder without clearing the flag.

The boot flag is the only storage element. All decoding is combinational from the address, the base values and the straps.

Top module: `boot_overlay_decode`

## Requirements
- R1: With `req_i` low, all three selects are low. At no time is more than one select high.
- R2: For a read request exactly one select is high. The priority is ROM first (boot overlay or visible window), then on-card RAM, then external bus.
- R3: In 1 KiB mode (`rom_2k_i`=0), the ROM window matches when `addr_i[15:10]` equals `rom_base_i`. `rom_addr_o` is then {1'b0, `addr_i[9:0]`}.
- R4: In 2 KiB mode, `addr_i[10]` is left out of the compare and the compare is made against a zero in that bit position. An odd `rom_base_i` therefore never matches. `rom_addr_o` is `addr_i[10:0]`.
- R5: The RAM window matches when `addr_i[15:10]` equals `ram_base_i`. `ram_addr_o` is `addr_i[9:0]`.
- R6: A write never selects the ROM. It selects the RAM on a RAM window match, and the external bus otherwise.
- R7: Reset sets the boot flag. While the flag is set and `boot_jump_i`=1, every read selects the ROM, whatever the address.
- R8: A request with `peek_i`=0 that matches the ROM window clears the flag at that clock edge. This applies to reads and to writes. A read that clears the flag is itself still served by the ROM.
- R9: A request with `peek_i`=1 never clears the flag.
- R10: With `rom_win_dis_i`=1, a read in the ROM window selects the ROM only through the boot overlay. Once the flag is cleared, such reads go to RAM or to the external bus.
- R11: With `boot_jump_i`=0 there is no overlay. Reads outside the ROM window do not select the ROM, even straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; sets the boot flag |
| req_i | input | 1 | Memory request qualifier |
| we_i | input | 1 | 1 = write, 0 = read |
| peek_i | input | 1 | Side-effect-free debug access |
| addr_i | input | 16 | Processor address |
| rom_base_i | input | 6 | ROM page base |
| ram_base_i | input | 6 | RAM page base |
| rom_2k_i | input | 1 | 1 = 2 KiB ROM, 0 = 1 KiB ROM |
| boot_jump_i | input | 1 | Enables the boot overlay |
| rom_win_dis_i | input | 1 | Hides the ROM window (phantom) |
| rom_sel_o | output | 1 | ROM answers |
| ram_sel_o | output | 1 | On-card RAM answers |
| ext_sel_o | output | 1 | External bus answers |
| rom_addr_o | output | 11 | ROM local offset |
| ram_addr_o | output | 10 | RAM local offset |

## Verification
The bench goes after the corner cases of the boot flag.

- A peek into the ROM window must leave the overlay in place. A design that ignores `peek_i` would drop the overlay early, and the next read outside the window would go to the external bus.
- A read that clears the flag must still select the ROM. A design that decides with the already-cleared flag would send that read to the bus while in phantom mode.
- A write into the window must clear the flag but must never select the ROM.

The bench also covers the address corners:

- An odd base in 2 KiB mode must not match. A design that simply drops bit 10 would match it.
- `addr_i[10]` must reach `rom_addr_o` only in 2 KiB mode.
- When the ROM and RAM windows overlap, the ROM must win for reads and the RAM for writes.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned PAGE_W = 10;
  localparam int unsigned BASE_W = ADDR_W - PAGE_W;
  localparam int unsigned ROM_AW = PAGE_W + 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_EXT  = 2'd3
  } tgt_e;
endpackage

// File: rtl/page_match.sv
module page_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 10,
  parameter bit          SIZED  = 1'b0,
  localparam int unsigned BASE_W = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              wide_i,
  output logic              hit_o
);
  logic [BASE_W-1:0] page;
  logic [BASE_W-1:0] mask;

  assign page = addr_i[ADDR_W-1:PAGE_W];

  generate
    if (SIZED) begin : g_sized
      // wide window: drop the low page bit of the address only
      assign mask = wide_i ? {{(BASE_W-1){1'b1}}, 1'b0} : {BASE_W{1'b1}};
    end else begin : g_fixed
      assign mask = {BASE_W{1'b1}};
    end
  endgenerate

  assign hit_o = ((page & mask) == base_i);
endmodule

// File: rtl/boot_flag.sv
module boot_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tgt_arb.sv
module tgt_arb
  import boot_dec_pkg::*;
(
  input  logic req_i,
  input  logic we_i,
  input  logic overlay_i,
  input  logic rom_vis_i,
  input  logic ram_hit_i,
  output tgt_e tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (req_i) begin
      if (!we_i && (overlay_i || rom_vis_i)) tgt_o = TGT_ROM;
      else if (ram_hit_i)                    tgt_o = TGT_RAM;
      else                                   tgt_o = TGT_EXT;
    end
  end
endmodule

// File: rtl/boot_overlay_decode.sv
module boot_overlay_decode
  import boot_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              peek_i,
  input  logic [15:0]       addr_i,
  input  logic [5:0]        rom_base_i,
  input  logic [5:0]        ram_base_i,
  input  logic              rom_2k_i,
  input  logic              boot_jump_i,
  input  logic              rom_win_dis_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              ext_sel_o,
  output logic [10:0]       rom_addr_o,
  output logic [9:0]        ram_addr_o
);
  logic rom_hit, ram_hit, boot_q, boot_clr;
  tgt_e tgt;

  page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZED(1'b1)) u_rom_match (
    .addr_i(addr_i), .base_i(rom_base_i), .wide_i(rom_2k_i), .hit_o(rom_hit)
  );

  page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZED(1'b0)) u_ram_match (
    .addr_i(addr_i), .base_i(ram_base_i), .wide_i(1'b0), .hit_o(ram_hit)
  );

  assign boot_clr = req_i && rom_hit && !peek_i;

  boot_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(boot_clr), .flag_o(boot_q)
  );

  tgt_arb u_arb (
    .req_i(req_i), .we_i(we_i),
    .overlay_i(boot_q && boot_jump_i),
    .rom_vis_i(rom_hit && !rom_win_dis_i),
    .ram_hit_i(ram_hit), .tgt_o(tgt)
  );

  assign rom_sel_o  = (tgt == TGT_ROM);
  assign ram_sel_o  = (tgt == TGT_RAM);
  assign ext_sel_o  = (tgt == TGT_EXT);
  assign rom_addr_o = {addr_i[PAGE_W] & rom_2k_i, addr_i[PAGE_W-1:0]};
  assign ram_addr_o = addr_i[PAGE_W-1:0];
endmodule

// File: rtl/boot_overlay_decode_chk.sv
module boot_overlay_decode_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_i,
  input logic peek_i,
  input logic rom_win_dis_i,
  input logic boot_jump_i,
  input logic rom_hit,
  input logic boot_q,
  input logic rom_sel_o,
  input logic ram_sel_o,
  input logic ext_sel_o
);
  assert_onehot0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o, ext_sel_o}));
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(rom_sel_o || ram_sel_o || ext_sel_o));
  assert_read_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |-> $countones({rom_sel_o, ram_sel_o, ext_sel_o}) == 1);
  assert_no_rom_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> !rom_sel_o);
  assert_overlay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && boot_q && boot_jump_i) |-> rom_sel_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rom_hit && !peek_i) |=> !boot_q);
  assert_peek_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boot_q) |-> $past(req_i && !peek_i && rom_hit));
  assert_phantom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rom_win_dis_i && !(boot_q && boot_jump_i)) |-> !rom_sel_o);
endmodule

bind boot_overlay_decode boot_overlay_decode_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .peek_i(peek_i),
  .rom_win_dis_i(rom_win_dis_i), .boot_jump_i(boot_jump_i), .rom_hit(rom_hit),
  .boot_q(boot_q), .rom_sel_o(rom_sel_o), .ram_sel_o(ram_sel_o),
  .ext_sel_o(ext_sel_o)
);

// File: tb/boot_overlay_decode_tb.sv
module boot_overlay_decode_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, peek_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [5:0]  rom_base_i = 6'h14, ram_base_i = 6'h37;
  logic        rom_2k_i = 1'b1, boot_jump_i = 1'b1, rom_win_dis_i = 1'b0;
  logic        rom_sel_o, ram_sel_o, ext_sel_o;
  logic [10:0] rom_addr_o;
  logic [9:0]  ram_addr_o;

  boot_overlay_decode u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [2:0]  sel;
    logic [10:0] ra;
    logic [9:0]  ma;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit model_boot;
  bit done = 0;

  function automatic bit m_rom_hit(logic [15:0] a);
    if (rom_2k_i) return ({a[15:11], 1'b0} == rom_base_i);
    return (a[15:10] == rom_base_i);
  endfunction

  task automatic acc(input bit rq, input bit w, input bit pk,
                     input logic [15:0] a, input string tag);
    exp_t e;
    bit hit;
    @(negedge clk_i);
    req_i = rq; we_i = w; peek_i = pk; addr_i = a;
    hit = m_rom_hit(a);
    e.tag = tag;
    e.sel = 3'b000;
    if (rq) begin
      if (!w && ((model_boot && boot_jump_i) || (hit && !rom_win_dis_i))) e.sel = 3'b100;
      else if (a[15:10] == ram_base_i) e.sel = 3'b010;
      else e.sel = 3'b001;
    end
    e.ra = rom_2k_i ? a[10:0] : {1'b0, a[9:0]};
    e.ma = a[9:0];
    exp_q.push_back(e);
    if (rq && hit && !pk) model_boot = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b0;
    model_boot = 1;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_cmp++;
        if ({rom_sel_o, ram_sel_o, ext_sel_o} != e.sel) begin
          n_bad++;
          $display("FAIL %s sel act=%b exp=%b", e.tag,
                   {rom_sel_o, ram_sel_o, ext_sel_o}, e.sel);
        end else if (e.sel[2] && rom_addr_o != e.ra) begin
          n_bad++;
          $display("FAIL %s rom_addr act=%h exp=%h", e.tag, rom_addr_o, e.ra);
        end else if (e.sel[1] && ram_addr_o != e.ma) begin
          n_bad++;
          $display("FAIL %s ram_addr act=%h exp=%h", e.tag, ram_addr_o, e.ma);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    model_boot = 1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    acc(0, 0, 0, 16'h5000, "R1 idle after reset");
    acc(1, 0, 0, 16'h0000, "R7 overlay read 0000");
    acc(1, 0, 1, 16'h5123, "R9 peek into window");
    acc(1, 0, 0, 16'h1234, "R9 overlay kept after peek");
    acc(1, 1, 0, 16'hDC05, "R6 write to RAM during overlay");
    acc(1, 0, 0, 16'h5400, "R8 clearing read served by ROM, R4 offset");
    acc(1, 0, 0, 16'h1234, "R8 after clear goes external");
    acc(1, 0, 0, 16'hDC10, "R5 RAM read");
    acc(1, 0, 0, 16'h57FF, "R4 top of 2K window");
    acc(1, 0, 0, 16'h5800, "R4 past 2K window");
    acc(1, 1, 0, 16'h5000, "R6 write in ROM window");
    // 1K mode
    @(negedge clk_i); rom_2k_i = 1'b0; rom_base_i = 6'h15;
    acc(1, 0, 0, 16'h5456, "R3 1K window hit");
    acc(1, 0, 0, 16'h5000, "R3 1K neighbour page miss");
    // 2K with odd base
    @(negedge clk_i); rom_2k_i = 1'b1;
    acc(1, 0, 0, 16'h5400, "R4 odd base never matches");
    acc(1, 0, 0, 16'h5000, "R4 odd base never matches low");
    // overlapping windows
    @(negedge clk_i); rom_base_i = 6'h14; ram_base_i = 6'h14;
    acc(1, 0, 0, 16'h5010, "R2 ROM beats RAM on read");
    acc(1, 1, 0, 16'h5010, "R2 RAM takes write on overlap");
    acc(0, 1, 0, 16'h5010, "R1 no request no select");
    // phantom
    @(negedge clk_i); ram_base_i = 6'h37; rom_win_dis_i = 1'b1;
    do_reset();
    acc(1, 0, 0, 16'h8000, "R10 overlay while phantom");
    acc(1, 1, 0, 16'h5002, "R8 write clears flag");
    acc(1, 0, 0, 16'h5002, "R10 hidden window goes external");
    acc(1, 0, 0, 16'h0100, "R10 overlay gone");
    // phantom, clearing read
    do_reset();
    acc(1, 0, 0, 16'h5003, "R8 clearing read still ROM in phantom");
    acc(1, 0, 0, 16'h5003, "R10 next read external");
    // no boot jump
    @(negedge clk_i); rom_win_dis_i = 1'b0; boot_jump_i = 1'b0;
    do_reset();
    acc(1, 0, 0, 16'h0000, "R11 no overlay after reset");
    acc(1, 0, 0, 16'h5005, "R11 window still visible");
    acc(1, 0, 0, 16'hDC00, "R11 RAM normal");
    acc(0, 0, 0, 16'h0000, "R1 idle");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule